// File: doc/BRIEF.md
# No-Wait Pipelined Synchronous SRAM

This block models a synchronous static RAM whose data bus can carry a read in one cycle and a write in the next, or the reverse, without an idle turnaround slot. Every command input is registered on the rising clock edge. Read data leaves the block two enabled cycles after the command is captured. Write data enters the block two enabled cycles after the command is captured. Because both kinds of transfer use the same slot, a stream of mixed commands keeps the bus fully used.

A command starts when the load/advance input is low. A low write strobe gives a write and a high one gives a read. If any of the three chip selects is inactive, the command is a deselect. When the advance input is high, a two-bit burst counter moves the low address bits in linear or interleaved order, and the burst keeps the command type it was loaded with. A freeze input stops the whole pipeline. Each byte lane has its own write enable. A lane can be nine bits wide so that parity bits are stored as ordinary data.

Top module: `nws_sram`

## Requirements
- R1: A read command captured at enabled edge n makes `rvalid` high after enabled edge n+2. At that point `rdata` holds the word stored at the read address.
- R2: For a write command captured at enabled edge n, `wdata` is sampled at enabled edge n+2. Only lanes whose `lane_wr_n` bit was low in the command cycle are updated. Lane i is `wdata[9i+8:9i]`.
- R3: Reads and writes can alternate on consecutive cycles with no gap. A read issued in the cycle right after a write to the same address returns the newly merged word.
- R4: A load cycle selects the device only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination gives a deselect, which writes nothing.
- R5: When `burst_next`=1 on an unfrozen cycle, the command repeats the type of the last load. `wr_n`, the chip selects and `addr` are ignored. The upper address bits stay at the loaded value.
- R6: With `ilv_order`=0, the k-th advance after a load at start s uses low address bits (s+k) mod 4.
- R7: With `ilv_order`=1, the k-th advance after a load at start s uses low address bits s XOR k.
- R8: While `freeze`=1, no register or memory cell changes and all command and data inputs are ignored. On release, the pipeline continues where it stopped.
- R9: Reset sets `rvalid`=0 and `rdata`=0. Commands that are in flight when reset arrives are dropped and do not write the memory.
- R10: `rvalid` is low in the output slot of every write or deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| freeze | input | 1 | High suspends the whole pipeline |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 = load a new command, 1 = advance the burst |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data, two enabled cycles after its command |
| rdata | output | LANES*LANE_W | Read data, registered |
| rvalid | output | 1 | High in a slot that carries read data |

## Verification
The assertions check on every cycle that `rvalid` follows the operation held in the second pipeline stage, that a freeze holds the stage registers and the outputs, that a failed chip select produces an empty stage, and that a burst never leaves its four-word block. The memory contents can only be shown by the bench scenarios, which use a reference memory. These cover lane merging, read-after-write with no gap, the linear and interleaved orders, writes suppressed by a deselect, and dropping in-flight writes at reset.

// File: rtl/nws_pkg.sv
package nws_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits for burst position k from start s.
  function automatic logic [1:0] burst_low(input logic [1:0] s, input logic [1:0] k,
                                           input logic ilv);
    return ilv ? (s ^ k) : (s + k);
  endfunction

  // Merge a new word into an old one under a per-lane enable mask.
  function automatic logic [35:0] lane_merge9x4(input logic [35:0] old_w,
                                                input logic [35:0] new_w,
                                                input logic [3:0] en);
    logic [35:0] r;
    r = old_w;
    for (int i = 0; i < 4; i++) if (en[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction
endpackage

// File: rtl/nws_cmd.sv
module nws_cmd
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              burst_next,
  input  logic              wr_n,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_lanes
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  op_e               burst_op_q;

  wire chip_sel = !cs0_n && cs1 && !cs2_n;
  wire load_cyc = !freeze && !burst_next;
  wire step_cyc = !freeze && burst_next;

  logic [1:0]        step_nx;
  op_e               load_op;
  logic [ADDR_W-1:0] step_addr;

  assign step_nx   = step_q + 2'd1;
  assign step_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nx, ilv_order)};

  always_comb begin
    if (!chip_sel)  load_op = OP_NONE;
    else if (wr_n)  load_op = OP_RD;
    else            load_op = OP_WR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      step_q     <= '0;
      burst_op_q <= OP_NONE;
      s1_op      <= OP_NONE;
      s1_addr    <= '0;
      s1_lanes   <= '0;
    end else if (load_cyc) begin
      base_q     <= addr;
      step_q     <= '0;
      burst_op_q <= load_op;
      s1_op      <= load_op;
      s1_addr    <= addr;
      s1_lanes   <= ~lane_wr_n;
    end else if (step_cyc) begin
      step_q     <= step_nx;
      s1_op      <= burst_op_q;
      s1_addr    <= step_addr;
      s1_lanes   <= ~lane_wr_n;
    end
  end

  assert_deselect_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cyc && !chip_sel) |=> (s1_op == OP_NONE));

  assert_burst_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_cyc |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  assert_cmd_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s1_lanes)));
endmodule

// File: rtl/nws_stage.sv
module nws_stage
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  output op_e               out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_lanes
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_op    <= OP_NONE;
      out_addr  <= '0;
      out_lanes <= '0;
    end else if (!freeze) begin
      out_op    <= in_op;
      out_addr  <= in_addr;
      out_lanes <= in_lanes;
    end
  end

  assert_stage_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(out_op) && $stable(out_addr)));
endmodule

// File: rtl/nws_store.sv
module nws_store
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    freeze,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  wire commit_wr = rst_n && !freeze && (s2_op == OP_WR);
  wire commit_rd = !freeze && (s2_op == OP_RD);

  logic [DATA_W-1:0] cell_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    wire lane_we = commit_wr && s2_lanes[g];
    always_ff @(posedge clk) begin
      if (lane_we) cells[s2_addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign cell_word[g*LANE_W +: LANE_W] = cells[s2_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (!freeze) begin
      rvalid <= commit_rd;
      if (commit_rd) rdata <= cell_word;
    end
  end

  assert_read_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && s2_op == OP_RD) |=> rvalid);

  assert_no_valid_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && s2_op != OP_RD) |=> !rvalid);

  assert_out_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(rvalid) && $stable(rdata)));
endmodule

// File: rtl/nws_sram.sv
module nws_sram
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    freeze,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    burst_next,
  input  logic                    wr_n,
  input  logic                    ilv_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_lanes, s2_lanes;

  nws_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .burst_next(burst_next), .wr_n(wr_n), .ilv_order(ilv_order),
    .addr(addr), .lane_wr_n(lane_wr_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
  );

  nws_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .in_op(s1_op), .in_addr(s1_addr), .in_lanes(s1_lanes),
    .out_op(s2_op), .out_addr(s2_addr), .out_lanes(s2_lanes)
  );

  nws_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_lanes(s2_lanes),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // A write in stage 2 is followed by a read of stage 1 with no idle slot between them.
  assert_no_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && s2_op == OP_WR && s1_op == OP_RD) |=> (s2_op == OP_RD));
endmodule

// File: tb/test_nws_sram.sv
module test_nws_sram;
  import nws_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
  logic        burst_next = 1'b0, wr_n = 1'b1, ilv_order = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  lane_wr_n = '1;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nws_sram i_nws_sram (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .burst_next(burst_next), .wr_n(wr_n), .ilv_order(ilv_order),
    .addr(addr), .lane_wr_n(lane_wr_n), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  // Reference state: op codes 0 none, 1 read, 2 write
  logic [35:0] mdl [256];
  int          p1_op = 0, p2_op = 0, bop = 0;
  logic [7:0]  p1_a = 0, p2_a = 0, bb = 0;
  logic [3:0]  p1_en = 0, p2_en = 0;
  logic [1:0]  bk = 0;
  logic        exp_v = 0;
  logic [35:0] exp_d = 0;

  localparam logic [2:0] SEL = 3'b010;   // {cs0_n, cs1, cs2_n}
  localparam logic [2:0] OFF = 3'b111;

  function automatic logic [35:0] merge_ref(input logic [35:0] o, input logic [35:0] n,
                                            input logic [3:0] en);
    logic [35:0] r;
    for (int i = 0; i < 4; i++) r[i*9 +: 9] = en[i] ? n[i*9 +: 9] : o[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [1:0] order_ref(input logic [1:0] s, input logic [1:0] k,
                                           input logic ilv);
    logic [2:0] sum;
    sum = {1'b0, s} + {1'b0, k};
    return ilv ? {s[1] ^ k[1], s[0] ^ k[0]} : sum[1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit hold, input bit nxt, input bit rwn, input logic [2:0] ce,
                       input logic [7:0] a, input logic [3:0] mn, input bit ilv,
                       input string tag);
    logic [35:0] wd;
    int          op_n;
    logic [7:0]  a_n;
    wd = {4'($urandom), 32'($urandom)};
    freeze = hold; burst_next = nxt; wr_n = rwn;
    {cs0_n, cs1, cs2_n} = ce;
    addr = a; lane_wr_n = mn; ilv_order = ilv; wdata = wd;
    @(posedge clk);
    if (!hold) begin
      if (!nxt) begin
        bb = a; bk = 2'd0;
        bop = (ce == SEL) ? (rwn ? 1 : 2) : 0;
        a_n = a;
      end else begin
        bk = bk + 2'd1;
        a_n = {bb[7:2], order_ref(bb[1:0], bk, ilv)};
      end
      op_n = bop;
      if (p2_op == 2) mdl[p2_a] = merge_ref(mdl[p2_a], wd, p2_en);
      if (p2_op == 1) begin exp_v = 1'b1; exp_d = mdl[p2_a]; end
      else exp_v = 1'b0;
      p2_op = p1_op; p2_a = p1_a; p2_en = p1_en;
      p1_op = op_n;  p1_a = a_n;  p1_en = ~mn;
    end
    @(negedge clk);
    check(rvalid === exp_v, tag, "rvalid", {35'd0, rvalid}, {35'd0, exp_v});
    if (exp_v) check(rdata === exp_d, tag, "rdata", rdata, exp_d);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 1, OFF, 8'h00, 4'hf, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    p1_op = 0; p2_op = 0; bop = 0; bb = 0; bk = 0;
    exp_v = 0; exp_d = 0;
    check(rvalid === 1'b0, "R9", "rvalid after reset", {35'd0, rvalid}, 36'd0);
    check(rdata === 36'd0, "R9", "rdata after reset", rdata, 36'd0);
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    freeze = 1'b0;
    @(negedge clk);
    do_reset();

    // Fill every word with full-lane writes
    for (int a = 0; a < 256; a++) drive(0, 0, 0, SEL, 8'(a), 4'h0, 0, "R10");
    idle(2, "R10");

    // Read latency on a single read
    drive(0, 0, 1, SEL, 8'h33, 4'hf, 0, "R1");
    idle(2, "R1");

    // Partial lane write, then a read in the next cycle
    drive(0, 0, 0, SEL, 8'h05, 4'b1010, 0, "R2");
    drive(0, 0, 1, SEL, 8'h05, 4'hf, 0, "R3");
    drive(0, 0, 0, SEL, 8'h06, 4'b0110, 0, "R2");
    drive(0, 0, 1, SEL, 8'h06, 4'hf, 0, "R3");
    drive(0, 0, 0, SEL, 8'h07, 4'h0, 0, "R3");
    drive(0, 0, 1, SEL, 8'h07, 4'hf, 0, "R3");
    idle(2, "R3");

    // Each chip select inactive on its own: no write, no valid
    drive(0, 0, 0, 3'b110, 8'h10, 4'h0, 0, "R4");
    drive(0, 0, 0, 3'b000, 8'h10, 4'h0, 0, "R4");
    drive(0, 0, 0, 3'b011, 8'h10, 4'h0, 0, "R4");
    drive(0, 0, 1, 3'b011, 8'h10, 4'hf, 0, "R4");
    drive(0, 0, 1, SEL,    8'h10, 4'hf, 0, "R4");
    idle(2, "R4");

    // Write burst: selects, wr_n and addr ignored during advance
    drive(0, 0, 0, SEL, 8'h22, 4'h0, 0, "R5");
    for (int k = 0; k < 3; k++) drive(0, 1, 1, OFF, 8'hff, 4'h0, 0, "R5");
    drive(0, 0, 1, SEL, 8'h20, 4'hf, 0, "R5");
    for (int k = 0; k < 3; k++) drive(0, 1, 0, OFF, 8'h99, 4'hf, 0, "R5");
    idle(2, "R5");

    // Linear and interleaved read bursts from odd and even starts
    drive(0, 0, 1, SEL, 8'h41, 4'hf, 0, "R6");
    for (int k = 0; k < 4; k++) drive(0, 1, 1, SEL, 8'h00, 4'hf, 0, "R6");
    drive(0, 0, 1, SEL, 8'h43, 4'hf, 1, "R7");
    for (int k = 0; k < 3; k++) drive(0, 1, 1, SEL, 8'h00, 4'hf, 1, "R7");
    drive(0, 0, 1, SEL, 8'h52, 4'hf, 1, "R7");
    for (int k = 0; k < 3; k++) drive(0, 1, 1, SEL, 8'h00, 4'hf, 1, "R7");
    idle(2, "R7");

    // Freeze in mid-pipeline with a write and a read in flight
    drive(0, 0, 0, SEL, 8'h60, 4'b0011, 0, "R8");
    drive(0, 0, 1, SEL, 8'h33, 4'hf, 0, "R8");
    for (int k = 0; k < 3; k++) drive(1, 0, 0, SEL, 8'h61, 4'h0, 0, "R8");
    drive(0, 0, 1, SEL, 8'h60, 4'hf, 0, "R8");
    drive(1, 1, 0, SEL, 8'h62, 4'h0, 0, "R8");
    idle(3, "R8");
    drive(0, 0, 1, SEL, 8'h61, 4'hf, 0, "R8");
    idle(2, "R8");

    // Reset with two writes in flight
    drive(0, 0, 0, SEL, 8'h70, 4'h0, 0, "R9");
    drive(0, 0, 0, SEL, 8'h71, 4'h0, 0, "R9");
    do_reset();
    drive(0, 0, 1, SEL, 8'h70, 4'hf, 0, "R9");
    drive(0, 0, 1, SEL, 8'h71, 4'hf, 0, "R9");
    idle(2, "R9");

    // Random mixed traffic
    for (int i = 0; i < 4000; i++) begin
      bit         h, n;
      logic [2:0] ce;
      h  = ($urandom % 8) == 0;
      n  = ($urandom % 3) == 0;
      ce = (($urandom % 6) == 0) ? 3'($urandom) : SEL;
      drive(h, n, 1'($urandom), ce, 8'($urandom), 4'($urandom), 1'($urandom), "R1");
    end
    idle(2, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule